// File: doc/BRIEF.md
# Receive Ring Buffer Writer

The block places received Ethernet frames, one after another, into a circular byte buffer that a host drains. A frame enters as a byte stream with start-of-frame and end-of-frame marks, and its error and address-class flags are valid on the last byte. For each frame the block writes a four-byte header followed by the frame bytes, with the FCS bytes included. The header carries a status word and the frame length. The next frame begins at the next dword boundary after the current one.

The host reads frames from its own position and hands that position back through a register write. The value it writes is its consumed offset minus a fixed bias of 16 bytes. The block adds the bias back and keeps a buffer-empty flag that is set while the read and write positions are equal. It reports through two one-cycle events: one when a good frame is committed and one when a frame is dropped for lack of space. In wrap mode a frame that crosses the nominal end of the buffer continues linearly into a spill area past the end, so it is never split. With wrap mode off the bytes wrap to the start of the buffer. Taking the receive enable low returns both positions to zero.

Top module: `rx_ring_writer`

## Requirements
- R1: The header dword is written with byte strobe 4'hF and data {length[15:0], status[15:0]}, so lane 0 and lane 1 hold the status and lane 2 and lane 3 hold the length. The status bits are: bit0 good frame, bit1 alignment error (in_err[0]), bit2 CRC error (in_err[1]), bit3 long frame, bit4 runt, bit5 invalid symbol (in_err[2]), bit13 broadcast (in_cls[0]), bit14 physical match (in_cls[1]), bit15 multicast (in_cls[2]). Frame bytes use a one-hot strobe with the byte copied into all four lanes.
- R2: The length field equals the number of bytes received, FCS included. Byte i of the frame (i counted from 0) is stored at header offset + 4 + i.
- R3: On the first byte of a frame, a header is written with length 0xFFF0 and status 0. It stays in place while the frame is in progress, and it also stays after the frame is dropped.
- R4: After a frame is committed, the write position advances by (length + 4) rounded up to a multiple of 4, modulo the buffer length. The write position is always a multiple of 4.
- R5: A host write of value v sets the read position to (v + 16) mod 2^16 mod BUF_LEN. The buffer-empty flag is high exactly when the read and write positions are equal.
- R6: With wrap_en low, frame byte addresses wrap modulo BUF_LEN.
- R7: With wrap_en high, frame bytes continue linearly past BUF_LEN into a spill area of SPILL_LEN bytes. A byte whose address would be BUF_LEN + SPILL_LEN or more drops the frame.
- R8: While rx_en is low, the write position and the read position are both zero and no write is issued.
- R9: When byte number n (counted from 1) arrives and ((n + 7) & ~3) is not below the free space, the frame is dropped. The free space is (read - write) mod BUF_LEN, with 0 read as BUF_LEN. On a drop, ev_overflow pulses for one cycle, the write position is kept, no header is committed and the rest of the frame is ignored.
- R10: The runt bit is set when the length is below MIN_LEN. The long bit is set when the length is above MAX_LEN.
- R11: The good-frame bit is set only when no error flag, no runt and no long condition applies. ev_rx_ok pulses in the cycle of the final header write of a good frame, and only then.
- R12: The final header write is the last memory write of a frame. It comes three cycles after the last byte is accepted. Upstream leaves at least two idle cycles after a frame end.
- R13: After reset the write position is 0, the buffer is empty, and no write or event is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receiver enable; low clears both positions |
| wrap_en | input | 1 | Spill past the buffer end instead of wrapping frame bytes |
| in_valid | input | 1 | A frame byte is present |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_data | input | 8 | Frame byte |
| in_err | input | 3 | Error flags on the last byte: {symbol, crc, alignment} |
| in_cls | input | 3 | Address class on the last byte: {multicast, physical, broadcast} |
| host_rd_we | input | 1 | Host read-position write strobe |
| host_rd_val | input | 16 | Consumed offset minus 16 |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Byte address of the write |
| mem_be | output | 4 | Byte lane strobes |
| mem_wdata | output | 32 | Write data |
| wr_ptr | output | PTR_W | Current write position |
| buf_empty | output | 1 | Read and write positions are equal |
| ev_rx_ok | output | 1 | Good frame committed |
| ev_overflow | output | 1 | Frame dropped for lack of space |

## Verification
The bench sweeps the frame length from 1 to 40 bytes in both wrap modes, so frames start at every dword phase and cross the buffer end. A wrong rounding rule would leave the next header at an offset the host does not expect. A split at the wrong point would put bytes at the wrong address. The overflow cases fill the buffer until a frame needs exactly the free space, and until only one header's worth is left. A design with an off-by-one space check would commit a frame that makes a full buffer look empty. The spill case runs a frame to the last spill byte and then one byte further. The runt and long thresholds are tested on both sides, and the bias rollover at host value 0xFFF0 is tested as well.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
    typedef enum logic [2:0] {S_IDLE, S_RUN, S_LAST, S_HDR, S_DROP} wstate_e;

    localparam int ST_OK    = 0;
    localparam int ST_ALIGN = 1;
    localparam int ST_CRC   = 2;
    localparam int ST_LONG  = 3;
    localparam int ST_RUNT  = 4;
    localparam int ST_SYM   = 5;
    localparam int ST_BCAST = 13;
    localparam int ST_PHYS  = 14;
    localparam int ST_MCAST = 15;

    localparam logic [15:0] LEN_BUSY = 16'hFFF0;
endpackage

// File: rtl/rxring_status.sv
module rxring_status
    import rxring_pkg::*;
#(
    parameter int CNT_W   = 17,
    parameter int MIN_LEN = 64,
    parameter int MAX_LEN = 1518
) (
    input  logic [CNT_W-1:0] len,
    input  logic [2:0]       err,
    input  logic [2:0]       cls,
    output logic [15:0]      status
);
    logic is_runt, is_long;

    always_comb begin
        is_runt          = len < CNT_W'(MIN_LEN);
        is_long          = len > CNT_W'(MAX_LEN);
        status           = '0;
        status[ST_ALIGN] = err[0];
        status[ST_CRC]   = err[1];
        status[ST_SYM]   = err[2];
        status[ST_LONG]  = is_long;
        status[ST_RUNT]  = is_runt;
        status[ST_BCAST] = cls[0];
        status[ST_PHYS]  = cls[1];
        status[ST_MCAST] = cls[2];
        status[ST_OK]    = ~(|err | is_runt | is_long);
    end
endmodule

// File: rtl/rxring_space.sv
module rxring_space #(
    parameter int BUF_LEN   = 32768,
    parameter int SPILL_LEN = 1536,
    parameter int PTR_W     = 15,
    parameter int AW        = 16,
    parameter int CNT_W     = 17
) (
    input  logic [PTR_W-1:0] wr,
    input  logic [PTR_W-1:0] rd,
    input  logic [CNT_W-1:0] n,
    input  logic             wrap_en,
    output logic             fits,
    output logic [AW-1:0]    addr
);
    localparam int LW = CNT_W + 1;

    logic [PTR_W-1:0] gap;
    logic [LW-1:0]    room, need, lin;

    always_comb begin
        gap  = rd - wr;
        room = (gap == '0) ? LW'(BUF_LEN) : LW'(gap);
        need = (LW'(n) + LW'(7)) & ~LW'(3);
        lin  = LW'(wr) + LW'(3) + LW'(n);
        fits = (need < room) && (!wrap_en || (lin < LW'(BUF_LEN + SPILL_LEN)));
        addr = wrap_en ? AW'(lin) : AW'(lin[PTR_W-1:0]);
    end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
    import rxring_pkg::*;
#(
    parameter int BUF_LEN   = 32768,
    parameter int SPILL_LEN = 1536,
    parameter int MIN_LEN   = 64,
    parameter int MAX_LEN   = 1518,
    parameter int RD_BIAS   = 16,
    localparam int PTR_W    = $clog2(BUF_LEN),
    localparam int AW       = $clog2(BUF_LEN + SPILL_LEN),
    localparam int CNT_W    = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             wrap_en,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic [7:0]       in_data,
    input  logic [2:0]       in_err,
    input  logic [2:0]       in_cls,
    input  logic             host_rd_we,
    input  logic [15:0]      host_rd_val,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [3:0]       mem_be,
    output logic [31:0]      mem_wdata,
    output logic [PTR_W-1:0] wr_ptr,
    output logic             buf_empty,
    output logic             ev_rx_ok,
    output logic             ev_overflow
);
    typedef struct packed {
        wstate_e          state;
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       hold_data;
        logic [AW-1:0]    hold_addr;
        logic [2:0]       err;
        logic [2:0]       cls;
        logic             mem_we;
        logic [AW-1:0]    mem_addr;
        logic [3:0]       mem_be;
        logic [31:0]      mem_wdata;
        logic             ev_ok;
        logic             ev_ovf;
    } regs_t;

    regs_t r_q, r_d;

    logic             beat;
    logic [CNT_W-1:0] n_next;
    logic [CNT_W-1:0] hdr_step;
    logic             fits;
    logic [AW-1:0]    byte_addr;
    logic [15:0]      status;

    assign beat     = rx_en & in_valid;
    assign n_next   = (r_q.state == S_IDLE) ? CNT_W'(1) : r_q.cnt + 1'b1;
    assign hdr_step = (r_q.cnt + CNT_W'(7)) & ~CNT_W'(3);

    rxring_space #(
        .BUF_LEN(BUF_LEN), .SPILL_LEN(SPILL_LEN),
        .PTR_W(PTR_W), .AW(AW), .CNT_W(CNT_W)
    ) space_i (
        .wr(r_q.wr), .rd(r_q.rd), .n(n_next), .wrap_en(wrap_en),
        .fits(fits), .addr(byte_addr)
    );

    rxring_status #(
        .CNT_W(CNT_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)
    ) status_i (
        .len(r_q.cnt), .err(r_q.err), .cls(r_q.cls), .status(status)
    );

    always_comb begin
        r_d        = r_q;
        r_d.mem_we = 1'b0;
        r_d.ev_ok  = 1'b0;
        r_d.ev_ovf = 1'b0;
        if (!rx_en) begin
            r_d = '0;
        end else begin
            if (host_rd_we) begin
                r_d.rd = PTR_W'(host_rd_val + 16'(RD_BIAS));
            end
            case (r_q.state)
                S_IDLE, S_RUN: begin
                    if (beat && (r_q.state == S_RUN || in_sof)) begin
                        if (fits) begin
                            r_d.mem_we = 1'b1;
                            if (r_q.state == S_IDLE) begin
                                r_d.mem_addr  = AW'(r_q.wr);
                                r_d.mem_be    = 4'hF;
                                r_d.mem_wdata = {LEN_BUSY, 16'h0000};
                            end else begin
                                r_d.mem_addr  = r_q.hold_addr;
                                r_d.mem_be    = 4'b0001 << r_q.hold_addr[1:0];
                                r_d.mem_wdata = {4{r_q.hold_data}};
                            end
                            r_d.hold_data = in_data;
                            r_d.hold_addr = byte_addr;
                            r_d.cnt       = n_next;
                            if (in_eof) begin
                                r_d.err   = in_err;
                                r_d.cls   = in_cls;
                                r_d.state = S_LAST;
                            end else begin
                                r_d.state = S_RUN;
                            end
                        end else begin
                            r_d.ev_ovf = 1'b1;
                            r_d.state  = in_eof ? S_IDLE : S_DROP;
                        end
                    end
                end
                S_LAST: begin
                    r_d.mem_we    = 1'b1;
                    r_d.mem_addr  = r_q.hold_addr;
                    r_d.mem_be    = 4'b0001 << r_q.hold_addr[1:0];
                    r_d.mem_wdata = {4{r_q.hold_data}};
                    r_d.state     = S_HDR;
                end
                S_HDR: begin
                    r_d.mem_we    = 1'b1;
                    r_d.mem_addr  = AW'(r_q.wr);
                    r_d.mem_be    = 4'hF;
                    r_d.mem_wdata = {16'(r_q.cnt), status};
                    r_d.wr        = r_q.wr + PTR_W'(hdr_step);
                    r_d.ev_ok     = status[ST_OK];
                    r_d.state     = S_IDLE;
                end
                S_DROP: begin
                    if (beat && in_eof) r_d.state = S_IDLE;
                end
                default: r_d.state = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mem_we      = r_q.mem_we;
    assign mem_addr    = r_q.mem_addr;
    assign mem_be      = r_q.mem_be;
    assign mem_wdata   = r_q.mem_wdata;
    assign wr_ptr      = r_q.wr;
    assign buf_empty   = (r_q.rd == r_q.wr);
    assign ev_rx_ok    = r_q.ev_ok;
    assign ev_overflow = r_q.ev_ovf;

    assert_wr_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr[1:0] == 2'b00);

    assert_strobe_shape_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_be == 4'hF || $countones(mem_be) == 1));

    assert_addr_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ({1'b0, mem_addr} < CNT_W'(BUF_LEN + SPILL_LEN)));

    assert_off_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (wr_ptr == '0 && buf_empty && !mem_we));

    assert_no_advance_on_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_overflow |-> wr_ptr == $past(wr_ptr));

    assert_ok_with_header_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_ok |-> (mem_we && mem_be == 4'hF && mem_wdata[0]));
endmodule

// File: tb/rx_ring_writer_tb_top.sv
`timescale 1ns/1ps
module rx_ring_writer_tb_top;
    localparam int BL = 256;
    localparam int SP = 64;
    localparam int MN = 16;
    localparam int MX = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_en = 1'b0, wrap_en = 1'b0;
    logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0] in_data = '0;
    logic [2:0] in_err = '0, in_cls = '0;
    logic host_rd_we = 1'b0;
    logic [15:0] host_rd_val = '0;
    logic mem_we;
    logic [8:0] mem_addr;
    logic [3:0] mem_be;
    logic [31:0] mem_wdata;
    logic [7:0] wr_ptr;
    logic buf_empty, ev_rx_ok, ev_overflow;

    always #5 clk = ~clk;

    rx_ring_writer #(.BUF_LEN(BL), .SPILL_LEN(SP), .MIN_LEN(MN), .MAX_LEN(MX), .RD_BIAS(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .wrap_en(wrap_en),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
        .in_err(in_err), .in_cls(in_cls), .host_rd_we(host_rd_we), .host_rd_val(host_rd_val),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .wr_ptr(wr_ptr), .buf_empty(buf_empty), .ev_rx_ok(ev_rx_ok), .ev_overflow(ev_overflow)
    );

    logic [7:0] mem [BL+SP];
    int last_addr = -1, last_be = 0, wcount = 0, ok_cnt = 0, ovf_cnt = 0;
    int errors = 0, checks = 0;
    int m_wr = 0;

    always @(negedge clk) begin
        if (mem_we) begin
            for (int l = 0; l < 4; l++)
                if (mem_be[l] && ((int'(mem_addr) & ~3) + l) < BL + SP)
                    mem[(int'(mem_addr) & ~3) + l] = mem_wdata[8*l +: 8];
            last_addr = int'(mem_addr);
            last_be   = int'(mem_be);
            wcount++;
        end
        if (ev_rx_ok) ok_cnt++;
        if (ev_overflow) ovf_cnt++;
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(int len, int i);
        return 8'((len * 7 + i * 3 + 1) & 255);
    endfunction

    function automatic int exp_st(int len, logic [2:0] e, logic [2:0] c);
        logic [15:0] s;
        s = '0;
        s[1] = e[0]; s[2] = e[1]; s[5] = e[2];
        s[4] = (len < MN); s[3] = (len > MX);
        s[13] = c[0]; s[14] = c[1]; s[15] = c[2];
        s[0] = !((|e) || s[4] || s[3]);
        return int'(s);
    endfunction

    function automatic int hdr_len(int a);
        return {mem[a+3], mem[a+2]};
    endfunction

    task automatic send(int len, logic [2:0] e, logic [2:0] c, bit pause);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == len - 1);
            in_data = pat(len, i); in_err = e; in_cls = c;
            if (pause && i == 0 && len > 1) begin
                @(negedge clk);
                in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
                @(negedge clk); #1;
                chk("R3 sentinel length while in progress", hdr_len(m_wr), 16'hFFF0);
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        repeat (4) @(negedge clk);
        #1;
    endtask

    task automatic good_frame(int len, logic [2:0] e, logic [2:0] c, bit pause);
        int okb, a, bad, st, ad;
        okb = ok_cnt; a = m_wr;
        st = exp_st(len, e, c);
        send(len, e, c, pause);
        chk("R2 header length", hdr_len(a), len);
        chk("R1 header status", {mem[a+1], mem[a]}, st);
        bad = 0;
        for (int i = 0; i < len; i++) begin
            ad = wrap_en ? a + 4 + i : (a + 4 + i) % BL;
            if (mem[ad] != pat(len, i)) bad++;
        end
        chk(wrap_en ? "R7 linear byte placement" : "R6 wrapped byte placement", bad, 0);
        chk("R12 header is last write addr", last_addr, a);
        chk("R12 header is last write strobe", last_be, 15);
        m_wr = (a + ((len + 7) / 4) * 4) % BL;
        chk("R4 next frame offset", int'(wr_ptr), m_wr);
        chk("R11 good-frame event count", ok_cnt - okb, st & 1);
    endtask

    task automatic host_read(int consumed);
        @(negedge clk);
        host_rd_we = 1'b1; host_rd_val = 16'((consumed - 16) & 16'hFFFF);
        @(negedge clk);
        host_rd_we = 1'b0;
        #1;
    endtask

    task automatic toggle_rx();
        @(negedge clk); rx_en = 1'b0;
        @(negedge clk); #1;
        chk("R8 write position cleared", int'(wr_ptr), 0);
        chk("R8 empty while off", int'(buf_empty), 1);
        @(negedge clk); rx_en = 1'b1;
        #1;
        m_wr = 0;
    endtask

    initial begin
        #1_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int ob, wb, okb;
        for (int i = 0; i < BL + SP; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R13 reset write position", int'(wr_ptr), 0);
        chk("R13 reset empty", int'(buf_empty), 1);
        chk("R13 reset no write", int'(mem_we), 0);
        chk("R13 reset no events", int'(ev_rx_ok | ev_overflow), 0);
        rx_en = 1'b1;

        // R5 bias rollover: 0xFFF0 + 16 -> 0
        host_read(0);
        chk("R5 bias rollover gives empty", int'(buf_empty), 1);
        host_read(16);
        chk("R5 offset read position not empty", int'(buf_empty), 0);
        host_read(0);

        // R3 sentinel with a paused frame
        good_frame(24, 3'b000, 3'b001, 1'b1);
        host_read(m_wr);
        chk("R5 empty after host catches up", int'(buf_empty), 1);

        // sweep in both wrap modes
        for (int w = 0; w < 2; w++) begin
            toggle_rx();
            wrap_en = w[0];
            for (int len = 1; len <= 40; len++) begin
                good_frame(len, 3'b000, 3'(len % 8), 1'b0);
                chk("R5 not empty before host read", int'(buf_empty), 0);
                host_read(m_wr);
                chk("R5 empty after host read", int'(buf_empty), 1);
            end
        end

        // R10 thresholds and R1 flag sweep
        toggle_rx();
        wrap_en = 1'b0;
        good_frame(MN - 1, 3'b000, 3'b000, 1'b0); host_read(m_wr);
        good_frame(MN,     3'b000, 3'b000, 1'b0); host_read(m_wr);
        good_frame(MX,     3'b000, 3'b000, 1'b0); host_read(m_wr);
        good_frame(MX + 1, 3'b000, 3'b000, 1'b0); host_read(m_wr);
        chk("R10 long bit above max", int'(mem[(m_wr + BL - 108) % BL][3]), 1);
        for (int e = 0; e < 8; e++) begin
            good_frame(20, 3'(e), 3'(7 - e), 1'b0);
            host_read(m_wr);
        end

        // R9 overflow
        toggle_rx();
        for (int k = 0; k < 3; k++) good_frame(60, 3'b000, 3'b000, 1'b0);
        ob = ovf_cnt; okb = ok_cnt;
        send(60, 3'b000, 3'b000, 1'b0);
        chk("R9 drop pulses overflow", ovf_cnt - ob, 1);
        chk("R9 drop keeps write position", int'(wr_ptr), 192);
        chk("R9 drop no good event", ok_cnt - okb, 0);
        chk("R3 sentinel stays after drop", hdr_len(192), 16'hFFF0);
        chk("R9 buffer not empty", int'(buf_empty), 0);
        good_frame(56, 3'b000, 3'b000, 1'b0);
        ob = ovf_cnt; wb = wcount;
        send(1, 3'b000, 3'b000, 1'b0);
        chk("R9 one-dword space drops at first byte", ovf_cnt - ob, 1);
        chk("R9 no write on drop at first byte", wcount - wb, 0);
        chk("R9 write position kept", int'(wr_ptr), 252);
        host_read(252);
        chk("R5 empty after full drain", int'(buf_empty), 1);

        // R7 spill boundary and R6 split
        toggle_rx();
        for (int k = 0; k < 4; k++) begin good_frame(56, 3'b000, 3'b000, 1'b0); host_read(m_wr); end
        wrap_en = 1'b1;
        good_frame(76, 3'b000, 3'b000, 1'b0);
        chk("R7 last spill byte written", int'(mem[319]), int'(pat(76, 75)));
        toggle_rx();
        wrap_en = 1'b0;
        for (int k = 0; k < 4; k++) begin good_frame(56, 3'b000, 3'b000, 1'b0); host_read(m_wr); end
        wrap_en = 1'b1;
        ob = ovf_cnt;
        send(77, 3'b000, 3'b000, 1'b0);
        chk("R7 beyond spill drops", ovf_cnt - ob, 1);
        chk("R7 beyond spill keeps position", int'(wr_ptr), 240);
        wrap_en = 1'b0;
        good_frame(77, 3'b000, 3'b000, 1'b0);
        chk("R6 split frame next offset", int'(wr_ptr), 68);

        toggle_rx();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule